// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block records the value of a free-running 16-bit counter when a chosen edge appears on an external capture input. A control bit selects whether rising or falling edges count. On a qualifying edge the whole counter word is stored in a capture register, which software cannot write, and a capture flag goes high in the same clock. Software clears the flag by writing a one to it.

An 8-bit processor reads the 16-bit capture value through a byte-wide read port. Reading the low byte also copies the captured high byte into a temporary byte latch. A following high-byte read returns that latch, so the two halves always belong to the same capture. The latch is shared with other byte-wide 16-bit accesses elsewhere in the timer, which reach it through a separate write strobe. An unrelated access that comes between the two reads therefore changes what the high read returns.

Top module: `edge_capture_unit`

## Requirements
- R1: After synchronous reset the capture flag is 0, and reads of both the low byte and the high byte return 0x00.
- R2: With `edge_rise` = 1, a 0-to-1 transition on `cap_pin` captures `count_in`, and a 1-to-0 transition captures nothing.
- R3: With `edge_rise` = 0, a 1-to-0 transition on `cap_pin` captures `count_in`, and a 0-to-1 transition captures nothing.
- R4: The pin passes through a two-stage synchronizer. When `cap_pin` changes ahead of rising clock edge k, the capture register loads the value `count_in` holds at edge k+2.
- R5: The capture flag goes high on the same clock edge on which the capture register loads.
- R6: A read with `rd_sel` = 0 puts bits [7:0] of the capture register on `rd_data` one cycle later and copies bits [15:8] into the temporary latch.
- R7: A read with `rd_sel` = 1 puts the temporary latch on `rd_data` one cycle later. It does not read the live capture register, so a capture that lands between a low read and a high read does not reach the high result.
- R8: A one on `flag_clr` clears the capture flag at the next clock edge.
- R9: If a capture and `flag_clr` occur on the same edge, the flag is left set.
- R10: A new capture overwrites the capture register even while the flag is still set.
- R11: `tmp_ext_we` loads `tmp_ext_data` into the shared latch, and a later high read returns it. A low read on the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| edge_rise | input | 1 | 1 = rising edge captures, 0 = falling edge captures |
| count_in | input | 16 | Free-running counter value |
| flag_clr | input | 1 | Write-one-to-clear strobe for the capture flag |
| rd_en | input | 1 | Byte read strobe |
| rd_sel | input | 1 | 0 = low byte, 1 = high byte (temporary latch) |
| tmp_ext_we | input | 1 | Write strobe into the shared temporary latch from other 16-bit accesses |
| tmp_ext_data | input | 8 | Data for the shared temporary latch |
| rd_data | output | 8 | Registered read data |
| cap_flag | output | 1 | Capture flag |

## Verification
A pin change made before edge k shows up as a capture and a raised flag after edge k+2. The bench drives the pin at a falling clock edge, samples the flag after each of the next three rising edges, and changes `count_in` every cycle so that only the value held at edge k+2 matches. Read data and flag clears take effect one edge after their strobe, so each check samples at the falling edge that follows that rising edge. Cases that must capture nothing wait four cycles and then confirm that both the flag and the register, read back through the port, are unchanged.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
    parameter int unsigned BYTE_W      = 8;
    parameter int unsigned SYNC_STAGES = 2;
    localparam int unsigned CNT_W      = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } cap_word_t;

    function automatic logic edge_match(input logic cur, input logic prev,
                                        input logic rise_sel);
        return rise_sel ? (cur & ~prev) : (~cur & prev);
    endfunction
endpackage

// File: rtl/ecu_edge_sync.sv
module ecu_edge_sync
    import ecu_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic fire
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign fire = edge_match(chain_q[STAGES-1], prev_q, rise_sel);

    // R2
    rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && rise_sel) |=> (prev_q == 1'b1));
    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !rise_sel) |=> (prev_q == 1'b0));
endmodule

// File: rtl/ecu_capture_reg.sv
module ecu_capture_reg
    import ecu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  cnt_t      count_in,
    input  logic      flag_clr,
    output cap_word_t cap_q,
    output logic      flag_q
);
    always_ff @(posedge clk) begin
        if (rst)       cap_q <= '0;
        else if (fire) cap_q <= cap_word_t'(count_in);
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_t'(cap_q) == $past(count_in)));
    // R5
    flag_with_capture_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag_q);
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !fire) |=> !flag_q);
    // R10
    hold_without_fire_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(cap_q));
endmodule

// File: rtl/ecu_read_port.sv
module ecu_read_port
    import ecu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cap_word_t cap_q,
    input  logic      rd_en,
    input  byte_sel_e rd_sel,
    input  logic      ext_we,
    input  byte_t     ext_data,
    output byte_t     rd_data
);
    byte_t tmp_q;
    logic  lo_read;
    logic  hi_read;

    assign lo_read = rd_en && (rd_sel == SEL_LO);
    assign hi_read = rd_en && (rd_sel == SEL_HI);

    always_ff @(posedge clk) begin
        if (rst)          tmp_q <= '0;
        else if (lo_read) tmp_q <= cap_q.hi;
        else if (ext_we)  tmp_q <= ext_data;
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (lo_read) rd_data <= cap_q.lo;
        else if (hi_read) rd_data <= tmp_q;
    end

    // R6
    low_read_chk: assert property (@(posedge clk) disable iff (rst)
        lo_read |=> (rd_data == $past(cap_q.lo)) && (tmp_q == $past(cap_q.hi)));
    // R7
    high_read_chk: assert property (@(posedge clk) disable iff (rst)
        hi_read |=> (rd_data == $past(tmp_q)));
    // R11
    ext_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_we && !lo_read) |=> (tmp_q == $past(ext_data)));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_pin,
    input  logic        edge_rise,
    input  logic [15:0] count_in,
    input  logic        flag_clr,
    input  logic        rd_en,
    input  logic        rd_sel,
    input  logic        tmp_ext_we,
    input  logic [7:0]  tmp_ext_data,
    output logic [7:0]  rd_data,
    output logic        cap_flag
);
    logic      fire;
    cap_word_t cap_q;
    byte_t     rd_byte;

    ecu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (cap_pin),
        .rise_sel (edge_rise),
        .fire     (fire)
    );

    ecu_capture_reg u_cap (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .count_in (cnt_t'(count_in)),
        .flag_clr (flag_clr),
        .cap_q    (cap_q),
        .flag_q   (cap_flag)
    );

    ecu_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .cap_q    (cap_q),
        .rd_en    (rd_en),
        .rd_sel   (byte_sel_e'(rd_sel)),
        .ext_we   (tmp_ext_we),
        .ext_data (byte_t'(tmp_ext_data)),
        .rd_data  (rd_byte)
    );

    assign rd_data = rd_byte;

    // R9
    capture_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && flag_clr) |=> cap_flag);
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_pin = 1'b0;
    logic        edge_rise = 1'b1;
    logic [15:0] count_in = '0;
    logic        flag_clr = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic        tmp_ext_we = 1'b0;
    logic [7:0]  tmp_ext_data = '0;
    logic [7:0]  rd_data;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edge_capture_unit uut (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .edge_rise(edge_rise),
        .count_in(count_in), .flag_clr(flag_clr), .rd_en(rd_en),
        .rd_sel(rd_sel), .tmp_ext_we(tmp_ext_we), .tmp_ext_data(tmp_ext_data),
        .rd_data(rd_data), .cap_flag(cap_flag)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_byte(input logic sel, output logic [7:0] val);
        rd_en = 1'b1; rd_sel = sel;
        tick();
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    task automatic capture(input logic lvl, input logic [15:0] val);
        count_in = val; cap_pin = lvl;
        tick(); tick(); tick();
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R1 flag", {15'd0, cap_flag}, 16'd0);
        read_byte(1'b0, b); check("R1 low", {8'd0, b}, 16'h0000);
        read_byte(1'b1, b); check("R1 high", {8'd0, b}, 16'h0000);
    endtask

    task automatic t_latency();
        logic [7:0] b;
        edge_rise = 1'b1;
        count_in = 16'h1111; cap_pin = 1'b1;
        tick(); count_in = 16'h2222;
        check("R4 no flag after edge 1", {15'd0, cap_flag}, 16'd0);
        tick(); count_in = 16'h3333;
        check("R4 no flag after edge 2", {15'd0, cap_flag}, 16'd0);
        tick(); count_in = 16'h4444;
        check("R5 flag after edge 3", {15'd0, cap_flag}, 16'd1);
        read_byte(1'b0, b); check("R4 low byte", {8'd0, b}, 16'h0033);
        read_byte(1'b1, b); check("R4 high byte", {8'd0, b}, 16'h0033);
    endtask

    task automatic t_rise_mode();
        logic [7:0] b;
        clear_flag();
        check("R8 flag cleared", {15'd0, cap_flag}, 16'd0);
        capture(1'b0, 16'hBEEF); tick();
        check("R2 falling ignored flag", {15'd0, cap_flag}, 16'd0);
        read_byte(1'b0, b); check("R2 falling ignored reg", {8'd0, b}, 16'h0033);
        capture(1'b1, 16'hC0DE);
        check("R2 rising captured flag", {15'd0, cap_flag}, 16'd1);
        read_byte(1'b0, b); check("R2 rising low", {8'd0, b}, 16'h00DE);
        read_byte(1'b1, b); check("R2 rising high", {8'd0, b}, 16'h00C0);
    endtask

    task automatic t_fall_mode();
        logic [7:0] b;
        clear_flag();
        edge_rise = 1'b0;
        capture(1'b0, 16'h5A5A);
        check("R3 falling captured flag", {15'd0, cap_flag}, 16'd1);
        read_byte(1'b0, b); check("R3 falling low", {8'd0, b}, 16'h005A);
        clear_flag();
        capture(1'b1, 16'h7777); tick();
        check("R3 rising ignored flag", {15'd0, cap_flag}, 16'd0);
        read_byte(1'b0, b); check("R3 rising ignored reg", {8'd0, b}, 16'h005A);
        edge_rise = 1'b1;
    endtask

    task automatic t_atomic_and_overwrite();
        logic [7:0] b;
        capture(1'b0, 16'h0000);
        capture(1'b1, 16'hA55A);
        check("R10 flag set", {15'd0, cap_flag}, 16'd1);
        read_byte(1'b0, b); check("R6 low", {8'd0, b}, 16'h005A);
        capture(1'b0, 16'h0000);
        capture(1'b1, 16'h1234);
        read_byte(1'b1, b); check("R7 high from latch", {8'd0, b}, 16'h00A5);
        read_byte(1'b0, b); check("R10 overwrite low", {8'd0, b}, 16'h0034);
        read_byte(1'b1, b); check("R10 overwrite high", {8'd0, b}, 16'h0012);
    endtask

    task automatic t_clear_priority();
        capture(1'b0, 16'h0000);
        check("R9 flag before", {15'd0, cap_flag}, 16'd1);
        count_in = 16'h9999; cap_pin = 1'b1;
        tick(); tick();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        check("R9 capture wins over clear", {15'd0, cap_flag}, 16'd1);
        clear_flag();
        check("R8 clear alone", {15'd0, cap_flag}, 16'd0);
    endtask

    task automatic t_shared_latch();
        logic [7:0] b;
        read_byte(1'b0, b); check("R6 low again", {8'd0, b}, 16'h0099);
        tmp_ext_we = 1'b1; tmp_ext_data = 8'h77; tick(); tmp_ext_we = 1'b0;
        read_byte(1'b1, b); check("R11 ext write corrupts high", {8'd0, b}, 16'h0077);
        tmp_ext_we = 1'b1; tmp_ext_data = 8'h3C;
        rd_en = 1'b1; rd_sel = 1'b0; tick();
        rd_en = 1'b0; tmp_ext_we = 1'b0;
        read_byte(1'b1, b); check("R11 low read wins", {8'd0, b}, 16'h0099);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        t_reset();
        t_latency();
        t_rise_mode();
        t_fall_mode();
        t_atomic_and_overwrite();
        t_clear_priority();
        t_shared_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule